// File: doc/BRIEF.md
# Exception PC and Vector Selector

This block sits at the retirement point of a 32-bit processor that retires instructions in order. Each cycle it may receive one retiring instruction together with its own address, the address of the instruction that would follow it, a set of exception flags, and a return-from-exception marker. Two asynchronous interrupt lines, a tick timer and an external request, are also sampled at instruction boundaries.

When an exception is taken, the block picks one cause by a fixed priority. It stores a return address in the exception PC register and copies the current status word into a saved-status register. It then sends fetch to the handler vector for that cause and raises a one-cycle flush. Which return address is stored depends on the class of the cause. Floating-point faults, system calls, tick timer interrupts and external interrupts store the address of the next instruction that was not executed. Instruction and data TLB misses store the faulting instruction's own address, so that the instruction runs again after the handler returns.

A return-from-exception sends fetch back to the stored address and restores the saved status word. The exception PC register can be read through the move-from-SPR port.

The control is a two-state machine. In `ST_RUN` the block accepts retiring instructions. `ST_RUN -> ST_FLUSH` happens whenever an exception or a return-from-exception redirects fetch. `ST_FLUSH -> ST_RUN` always happens after one cycle, and any retirement presented during `ST_FLUSH` is discarded as a younger, squashed instruction.

Top module: `exc_redirect_unit`

## Requirements
- R1: After reset, `flush_o` and `sr_load_o` are 0, `fetch_pc_o` is 0, and the exception PC register reads as 0.
- R2: A retiring instruction with `commit_fpu_exc_i` set, and no higher-priority cause, makes `flush_o` go to 1 and `fetch_pc_o` become 0x0000_0D00 on the next cycle. The exception PC register then holds `commit_npc_i`.
- R3: A system call (`commit_syscall_i`) vectors to 0x0C00, an accepted tick interrupt to 0x0500, and an accepted external interrupt to 0x0800. Each of these stores `commit_npc_i` in the exception PC register.
- R4: An instruction TLB miss vectors to 0x0A00 and a data TLB miss to 0x0900. Both store `commit_pc_i`, the faulting instruction's own address, in the exception PC register.
- R5: The priority from highest to lowest is: instruction TLB miss, data TLB miss, floating-point fault, system call, return-from-exception, tick interrupt, external interrupt.
- R6: An interrupt is accepted only when all of the following hold: a valid retirement is present, no synchronous cause or return-from-exception is present, and the enable bit in `sr_cur_i` is 1. The tick enable is bit 1 and the external enable is bit 2. A masked interrupt causes no flush and leaves the exception PC register unchanged.
- R7: `spr_rdata_o` returns the exception PC register when `spr_addr_i` equals 0x0020, and returns 0 for any other address.
- R8: A return-from-exception with no synchronous cause raises `flush_o` and `sr_load_o` on the next cycle, with `fetch_pc_o` equal to the exception PC register value from the cycle it retired.
- R9: `flush_o` is high for exactly one cycle per redirect. Retirements presented in the cycle when `flush_o` is high are ignored.
- R10: Taking an exception copies `sr_cur_i` into the saved status. The next return-from-exception presents that value on `sr_load_val_o`.
- R11: While `commit_valid_i` is 0, the exception flags and interrupt lines have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| commit_valid_i | input | 1 | A retiring instruction is present |
| commit_pc_i | input | 32 | Address of the retiring instruction |
| commit_npc_i | input | 32 | Address of the next instruction in program order |
| commit_itlb_miss_i | input | 1 | Instruction TLB miss on the retiring instruction |
| commit_dtlb_miss_i | input | 1 | Data TLB miss on the retiring instruction |
| commit_fpu_exc_i | input | 1 | Floating-point exception raised by the retiring instruction |
| commit_syscall_i | input | 1 | Retiring instruction is a system call |
| commit_rfe_i | input | 1 | Retiring instruction is a return-from-exception |
| tick_irq_i | input | 1 | Tick timer interrupt request |
| ext_irq_i | input | 1 | External interrupt request |
| sr_cur_i | input | 16 | Current status word (interrupt enables in bits 1 and 2) |
| spr_addr_i | input | 16 | Move-from-SPR address |
| spr_rdata_o | output | 32 | Move-from-SPR read data |
| flush_o | output | 1 | One-cycle redirect and flush pulse |
| fetch_pc_o | output | 32 | Redirect target, valid while `flush_o` is 1 |
| sr_load_o | output | 1 | Restore the status word from `sr_load_val_o` |
| sr_load_val_o | output | 16 | Saved status word being restored |

## Verification
The assertions assume that the upstream pipeline never marks one retirement as both a return-from-exception and a faulting instruction. They also assume that the interrupt lines are only relevant while a retirement is valid. The stimulus respects the first assumption by raising the return-from-exception marker only on otherwise clean retirements. It leaves the squash window to the block: a retirement presented in the flush cycle is sent on purpose, to show that it is discarded.

// File: rtl/exc_redirect_pkg.sv
package exc_redirect_pkg;

    typedef enum logic [2:0] {
        C_NONE,
        C_ITLB,
        C_DTLB,
        C_FPU,
        C_SYSCALL,
        C_RFE,
        C_TICK,
        C_EXT
    } exc_cause_e;

    typedef enum logic {
        ST_RUN,
        ST_FLUSH
    } redir_state_e;

endpackage

// File: rtl/exc_prio_sel.sv
module exc_prio_sel
    import exc_redirect_pkg::*;
#(
    parameter int SR_W        = 16,
    parameter int TICK_EN_BIT = 1,
    parameter int EXT_EN_BIT  = 2
) (
    input  logic            accept_i,
    input  logic            itlb_i,
    input  logic            dtlb_i,
    input  logic            fpu_i,
    input  logic            sys_i,
    input  logic            rfe_i,
    input  logic            tick_i,
    input  logic            ext_i,
    input  logic [SR_W-1:0] sr_i,
    output exc_cause_e      cause_o
);

    logic tick_ok;
    logic ext_ok;

    always_comb begin
        tick_ok = tick_i && sr_i[TICK_EN_BIT];
        ext_ok  = ext_i && sr_i[EXT_EN_BIT];
        cause_o = C_NONE;
        if (accept_i) begin
            if (itlb_i)       cause_o = C_ITLB;
            else if (dtlb_i)  cause_o = C_DTLB;
            else if (fpu_i)   cause_o = C_FPU;
            else if (sys_i)   cause_o = C_SYSCALL;
            else if (rfe_i)   cause_o = C_RFE;
            else if (tick_ok) cause_o = C_TICK;
            else if (ext_ok)  cause_o = C_EXT;
        end
    end

endmodule

// File: rtl/exc_target_gen.sv
module exc_target_gen
    import exc_redirect_pkg::*;
#(
    parameter int          XLEN     = 32,
    parameter logic [31:0] VEC_ITLB = 32'h0000_0A00,
    parameter logic [31:0] VEC_DTLB = 32'h0000_0900,
    parameter logic [31:0] VEC_FPU  = 32'h0000_0D00,
    parameter logic [31:0] VEC_SYS  = 32'h0000_0C00,
    parameter logic [31:0] VEC_TICK = 32'h0000_0500,
    parameter logic [31:0] VEC_EXT  = 32'h0000_0800
) (
    input  exc_cause_e      cause_i,
    input  logic [XLEN-1:0] pc_i,
    input  logic [XLEN-1:0] npc_i,
    input  logic [XLEN-1:0] epcr_i,
    output logic [XLEN-1:0] target_o,
    output logic [XLEN-1:0] save_o,
    output logic            take_o,
    output logic            ret_o
);

    // Restartable faults return to the faulting address; all others resume after it.
    always_comb begin
        target_o = '0;
        save_o   = npc_i;
        take_o   = 1'b1;
        ret_o    = 1'b0;
        unique case (cause_i)
            C_ITLB:    begin target_o = VEC_ITLB[XLEN-1:0]; save_o = pc_i; end
            C_DTLB:    begin target_o = VEC_DTLB[XLEN-1:0]; save_o = pc_i; end
            C_FPU:     target_o = VEC_FPU[XLEN-1:0];
            C_SYSCALL: target_o = VEC_SYS[XLEN-1:0];
            C_TICK:    target_o = VEC_TICK[XLEN-1:0];
            C_EXT:     target_o = VEC_EXT[XLEN-1:0];
            C_RFE:     begin target_o = epcr_i; take_o = 1'b0; ret_o = 1'b1; end
            C_NONE:    take_o = 1'b0;
            default:   take_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/exc_redirect_unit.sv
module exc_redirect_unit
    import exc_redirect_pkg::*;
#(
    parameter int          XLEN          = 32,
    parameter int          SR_W          = 16,
    parameter int          SPR_AW        = 16,
    parameter logic [15:0] EPCR_SPR_ADDR = 16'h0020,
    parameter int          TICK_EN_BIT   = 1,
    parameter int          EXT_EN_BIT    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit_valid_i,
    input  logic [XLEN-1:0]   commit_pc_i,
    input  logic [XLEN-1:0]   commit_npc_i,
    input  logic              commit_itlb_miss_i,
    input  logic              commit_dtlb_miss_i,
    input  logic              commit_fpu_exc_i,
    input  logic              commit_syscall_i,
    input  logic              commit_rfe_i,
    input  logic              tick_irq_i,
    input  logic              ext_irq_i,
    input  logic [SR_W-1:0]   sr_cur_i,
    input  logic [SPR_AW-1:0] spr_addr_i,
    output logic [XLEN-1:0]   spr_rdata_o,
    output logic              flush_o,
    output logic [XLEN-1:0]   fetch_pc_o,
    output logic              sr_load_o,
    output logic [SR_W-1:0]   sr_load_val_o
);

    localparam logic [SPR_AW-1:0] EPCR_ADDR = EPCR_SPR_ADDR[SPR_AW-1:0];

    redir_state_e    state_q, state_d;
    exc_cause_e      cause;
    logic            accept;
    logic [XLEN-1:0] epcr_q;
    logic [SR_W-1:0] esr_q;
    logic [XLEN-1:0] target;
    logic [XLEN-1:0] save_addr;
    logic            take_exc;
    logic            take_ret;

    // Younger instructions presented during the flush cycle are squashed.
    assign accept = commit_valid_i && (state_q == ST_RUN);

    exc_prio_sel #(
        .SR_W        (SR_W),
        .TICK_EN_BIT (TICK_EN_BIT),
        .EXT_EN_BIT  (EXT_EN_BIT)
    ) u_prio (
        .accept_i (accept),
        .itlb_i   (commit_itlb_miss_i),
        .dtlb_i   (commit_dtlb_miss_i),
        .fpu_i    (commit_fpu_exc_i),
        .sys_i    (commit_syscall_i),
        .rfe_i    (commit_rfe_i),
        .tick_i   (tick_irq_i),
        .ext_i    (ext_irq_i),
        .sr_i     (sr_cur_i),
        .cause_o  (cause)
    );

    exc_target_gen #(
        .XLEN (XLEN)
    ) u_target (
        .cause_i  (cause),
        .pc_i     (commit_pc_i),
        .npc_i    (commit_npc_i),
        .epcr_i   (epcr_q),
        .target_o (target),
        .save_o   (save_addr),
        .take_o   (take_exc),
        .ret_o    (take_ret)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:   if (take_exc || take_ret) state_d = ST_FLUSH;
            ST_FLUSH: state_d = ST_RUN;
            default:  state_d = ST_RUN;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    // Registered outputs and saved context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            epcr_q        <= '0;
            esr_q         <= '0;
            flush_o       <= 1'b0;
            fetch_pc_o    <= '0;
            sr_load_o     <= 1'b0;
            sr_load_val_o <= '0;
        end else begin
            flush_o   <= take_exc || take_ret;
            sr_load_o <= take_ret;
            if (take_exc || take_ret) fetch_pc_o <= target;
            if (take_ret) sr_load_val_o <= esr_q;
            if (take_exc) begin
                epcr_q <= save_addr;
                esr_q  <= sr_cur_i;
            end
        end
    end

    assign spr_rdata_o = (spr_addr_i == EPCR_ADDR) ? epcr_q : '0;

endmodule

// File: rtl/exc_redirect_chk.sv
module exc_redirect_chk #(
    parameter int XLEN = 32,
    parameter int SR_W = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            commit_valid_i,
    input logic [XLEN-1:0] commit_pc_i,
    input logic [XLEN-1:0] commit_npc_i,
    input logic            commit_itlb_miss_i,
    input logic            commit_dtlb_miss_i,
    input logic            commit_fpu_exc_i,
    input logic            commit_syscall_i,
    input logic            commit_rfe_i,
    input logic            tick_irq_i,
    input logic            ext_irq_i,
    input logic [SR_W-1:0] sr_cur_i,
    input logic            flush_o,
    input logic [XLEN-1:0] fetch_pc_o,
    input logic            sr_load_o,
    input logic [XLEN-1:0] epcr_q
);

    logic sync_any;
    assign sync_any = commit_itlb_miss_i || commit_dtlb_miss_i ||
                      commit_fpu_exc_i || commit_syscall_i;

    // R9
    flush_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_o |=> !flush_o);

    // R2
    fpu_redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_valid_i && !flush_o && commit_fpu_exc_i &&
         !commit_itlb_miss_i && !commit_dtlb_miss_i)
        |=> (flush_o && fetch_pc_o == 32'h0000_0D00 && epcr_q == $past(commit_npc_i)));

    // R4
    itlb_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_valid_i && !flush_o && commit_itlb_miss_i)
        |=> (flush_o && fetch_pc_o == 32'h0000_0A00 && epcr_q == $past(commit_pc_i)));

    // R8
    rfe_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_valid_i && !flush_o && commit_rfe_i && !sync_any)
        |=> (flush_o && sr_load_o && fetch_pc_o == $past(epcr_q)));

    // R6
    masked_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_valid_i && !flush_o && !sync_any && !commit_rfe_i &&
         !sr_cur_i[1] && !(ext_irq_i && sr_cur_i[2]))
        |=> (!flush_o && $stable(epcr_q)));

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!commit_valid_i && !flush_o) |=> (!flush_o && $stable(epcr_q)));

    // R8
    sr_load_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sr_load_o |-> flush_o);

endmodule

bind exc_redirect_unit exc_redirect_chk #(.XLEN(XLEN), .SR_W(SR_W)) u_chk (
    .clk                (clk),
    .rst_n              (rst_n),
    .commit_valid_i     (commit_valid_i),
    .commit_pc_i        (commit_pc_i),
    .commit_npc_i       (commit_npc_i),
    .commit_itlb_miss_i (commit_itlb_miss_i),
    .commit_dtlb_miss_i (commit_dtlb_miss_i),
    .commit_fpu_exc_i   (commit_fpu_exc_i),
    .commit_syscall_i   (commit_syscall_i),
    .commit_rfe_i       (commit_rfe_i),
    .tick_irq_i         (tick_irq_i),
    .ext_irq_i          (ext_irq_i),
    .sr_cur_i           (sr_cur_i),
    .flush_o            (flush_o),
    .fetch_pc_o         (fetch_pc_o),
    .sr_load_o          (sr_load_o),
    .epcr_q             (epcr_q)
);

// File: tb/tb_exc_redirect_unit.sv
module tb_exc_redirect_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid = 1'b0;
    logic [31:0] pc = '0, npc = '0;
    logic        itlb = 1'b0, dtlb = 1'b0, fpu = 1'b0, sys = 1'b0, rfe = 1'b0;
    logic        tick = 1'b0, ext = 1'b0;
    logic [15:0] sr = '0;
    logic [15:0] spr_addr = 16'h0020;
    logic [31:0] spr_rdata;
    logic        flush;
    logic [31:0] fetch_pc;
    logic        sr_load;
    logic [15:0] sr_load_val;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    exc_redirect_unit dut (
        .clk                (clk),
        .rst_n              (rst_n),
        .commit_valid_i     (valid),
        .commit_pc_i        (pc),
        .commit_npc_i       (npc),
        .commit_itlb_miss_i (itlb),
        .commit_dtlb_miss_i (dtlb),
        .commit_fpu_exc_i   (fpu),
        .commit_syscall_i   (sys),
        .commit_rfe_i       (rfe),
        .tick_irq_i         (tick),
        .ext_irq_i          (ext),
        .sr_cur_i           (sr),
        .spr_addr_i         (spr_addr),
        .spr_rdata_o        (spr_rdata),
        .flush_o            (flush),
        .fetch_pc_o         (fetch_pc),
        .sr_load_o          (sr_load),
        .sr_load_val_o      (sr_load_val)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic clear_in();
        valid = 0; itlb = 0; dtlb = 0; fpu = 0; sys = 0; rfe = 0; tick = 0; ext = 0;
    endtask

    // flags order: itlb dtlb fpu sys rfe tick ext
    task automatic retire(input logic [31:0] a, input logic [31:0] na, input logic [6:0] f,
                          input logic [15:0] s, input logic v);
        valid = v; pc = a; npc = na; sr = s;
        {itlb, dtlb, fpu, sys, rfe, tick, ext} = f;
        @(negedge clk);
        clear_in();
    endtask

    task automatic expect_redirect(input string tag, input logic [31:0] vec, input logic [31:0] ep);
        chk({tag, " flush"}, {31'b0, flush}, 32'd1);
        chk({tag, " vector"}, fetch_pc, vec);
        chk({tag, " epcr"}, spr_rdata, ep);
        @(negedge clk);
        chk({tag, " flush single R9"}, {31'b0, flush}, 32'd0);
    endtask

    task automatic t_reset();
        chk("R1 flush", {31'b0, flush}, 32'd0);
        chk("R1 sr_load", {31'b0, sr_load}, 32'd0);
        chk("R1 fetch_pc", fetch_pc, 32'd0);
        chk("R1 epcr", spr_rdata, 32'd0);
    endtask

    task automatic t_fpu();
        retire(32'h2370, 32'h2374, 7'b0010000, 16'h0000, 1);
        expect_redirect("R2 fpu", 32'h0D00, 32'h2374);
    endtask

    task automatic t_next_class();
        retire(32'h1000, 32'h1004, 7'b0001000, 16'h0000, 1);
        expect_redirect("R3 syscall", 32'h0C00, 32'h1004);
        retire(32'h2000, 32'h2004, 7'b0000010, 16'h0002, 1);
        expect_redirect("R3 tick", 32'h0500, 32'h2004);
        retire(32'h3000, 32'h3008, 7'b0000001, 16'h0004, 1);
        expect_redirect("R3 ext", 32'h0800, 32'h3008);
    endtask

    task automatic t_tlb();
        retire(32'hC05E2B20, 32'hC05E2B24, 7'b1000000, 16'h0, 1);
        expect_redirect("R4 itlb", 32'h0A00, 32'hC05E2B20);
        retire(32'hC05C8648, 32'hC05C864C, 7'b0100000, 16'h0, 1);
        expect_redirect("R4 dtlb", 32'h0900, 32'hC05C8648);
    endtask

    task automatic t_prio();
        retire(32'h4000, 32'h4004, 7'b1110011, 16'h0006, 1);
        expect_redirect("R5 itlb over all", 32'h0A00, 32'h4000);
        retire(32'h4100, 32'h4104, 7'b0110011, 16'h0006, 1);
        expect_redirect("R5 dtlb over fpu", 32'h0900, 32'h4100);
        retire(32'h4200, 32'h4204, 7'b0010011, 16'h0006, 1);
        expect_redirect("R5 fpu over irq", 32'h0D00, 32'h4204);
        retire(32'h4300, 32'h4304, 7'b0000011, 16'h0006, 1);
        expect_redirect("R5 tick over ext", 32'h0500, 32'h4304);
    endtask

    task automatic t_mask();
        retire(32'h5000, 32'h5004, 7'b0000011, 16'h0000, 1);
        chk("R6 masked no flush", {31'b0, flush}, 32'd0);
        chk("R6 masked epcr kept", spr_rdata, 32'h4304);
        retire(32'h5100, 32'h5104, 7'b0000010, 16'h0004, 1);
        chk("R6 tick with only ext enable", {31'b0, flush}, 32'd0);
        retire(32'h5200, 32'h5204, 7'b1111111, 16'h0006, 0);
        chk("R11 no valid no flush", {31'b0, flush}, 32'd0);
        chk("R11 no valid epcr kept", spr_rdata, 32'h4304);
    endtask

    task automatic t_spr();
        spr_addr = 16'h0021;
        #1;
        chk("R7 other addr reads 0", spr_rdata, 32'd0);
        spr_addr = 16'h0020;
        #1;
        chk("R7 epcr addr", spr_rdata, 32'h4304);
    endtask

    task automatic t_rfe();
        retire(32'h6000, 32'h6004, 7'b0010000, 16'h1234, 1);
        expect_redirect("R10 fpu save", 32'h0D00, 32'h6004);
        retire(32'h0D38, 32'h0D3C, 7'b0000100, 16'h0001, 1);
        chk("R8 rfe flush", {31'b0, flush}, 32'd1);
        chk("R8 rfe target", fetch_pc, 32'h6004);
        chk("R8 sr_load", {31'b0, sr_load}, 32'd1);
        chk("R10 sr restored", {16'b0, sr_load_val}, 32'h1234);
        @(negedge clk);
        chk("R8 sr_load single", {31'b0, sr_load}, 32'd0);
    endtask

    task automatic t_squash();
        retire(32'h7000, 32'h7004, 7'b0010000, 16'h0, 1);
        chk("R9 first flush", {31'b0, flush}, 32'd1);
        retire(32'h7004, 32'h7008, 7'b0001000, 16'h0, 1);
        chk("R9 squashed no flush", {31'b0, flush}, 32'd0);
        chk("R9 squashed epcr kept", spr_rdata, 32'h7004);
        chk("R9 target kept", fetch_pc, 32'h0D00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_fpu();
        t_next_class();
        t_tlb();
        t_prio();
        t_mask();
        t_spr();
        t_rfe();
        t_squash();
        @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule